// File: doc/BRIEF.md
# Three-Format 16-bit Instruction Decoder

This block takes one 16-bit instruction word per valid strobe and splits it into the fields that later stages of a small 32-bit core need. The two top bits of the word choose one of three layouts. The first layout has two register operands and an 8-bit opcode. The second has one register, a 2-bit sub-opcode and an unsigned 8-bit immediate. The third is a conditional branch, with a 4-bit condition code and a 10-bit word displacement.

Alongside the fields, the block reports whether the word is followed by a 32-bit literal, and so whether the whole instruction is 2 or 6 bytes long. It also flags codes that name no instruction, so that the core can raise a bad-instruction exception. All results are registered. They appear one clock after the input strobe, together with an output valid. Fetching the literal, executing the instruction and the register file all belong to other blocks.

Top module: `iword_decoder`

## Requirements
- R1: The form output is 1 when bit 15 is 0, 2 when bits [15:14] are 10, and 3 when bits [15:14] are 11. The value 0 never appears on a valid output.
- R2: For form 1, the opcode output is bits [15:8], reg_a is bits [7:4] and reg_b is bits [3:0]. imm8 and disp are 0.
- R3: For form 2, the opcode output is bits [13:12] zero-extended to 8 bits, reg_a is bits [11:8] and imm8 is bits [7:0]. reg_b and disp are 0. The four sub-opcodes are: 0 add immediate, 1 subtract immediate, 2 read special register, 3 write special register.
- R4: For form 3, the opcode output is bits [13:10] zero-extended. disp is bits [9:0], read as two's complement, multiplied by two and sign-extended to DISP_W bits; this is a byte offset. reg_a, reg_b and imm8 are 0.
- R5: The literal-consuming form 1 opcodes are 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39. These set needs_literal and give a length of 6. Every other word gives needs_literal 0 and a length of 2.
- R6: Form 1 opcodes 0x00 to 0x0E and 0x19 to 0x39 are legal. All other form 1 opcodes (0x0F to 0x18 and 0x3A to 0x7F) set illegal.
- R7: Form 3 condition codes 0 to 9 are legal and codes 10 to 15 set illegal. Form 2 words are never illegal.
- R8: out_valid is high in the cycle after a clock edge that samples in_valid high, and low in the cycle after one that samples it low. The fields shown are those of the word sampled at that edge.
- R9: While in_valid is low, every field output keeps its previous value, whatever in_word carries.
- R10: While rst_n is low at a clock edge, every output is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_word holds a word to decode |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Registered results are fresh |
| out_form | output | 2 | Layout: 1, 2 or 3 |
| out_opcode | output | 8 | Opcode, sub-opcode or condition code |
| out_reg_a | output | 4 | First register index |
| out_reg_b | output | 4 | Second register index (form 1) |
| out_imm8 | output | 8 | Unsigned immediate (form 2) |
| out_disp | output | DISP_W (16) | Signed byte displacement (form 3) |
| out_len | output | LEN_W (3) | Instruction length in bytes, 2 or 6 |
| out_needs_lit | output | 1 | A 32-bit literal follows the word |
| out_illegal | output | 1 | Word names no instruction |

## Verification
The bench streams every one of the 65536 words back to back, one per clock. This covers each opcode and each condition code under every operand pattern, so any field taken from the wrong bits of a layout, or handed to the wrong layout, shows up. The sweep also crosses both edges of each legal opcode range and every entry of the literal set. Negative, zero and extreme displacements separate a correct sign extension and doubling from a plain copy. A pause in the strobe, with a different word held on the input, separates holding the fields from loading them. Asserting reset with a strobe present separates reset from a normal load.

// File: rtl/iwd_pkg.sv
// Shared types and constants for the instruction decoder.
// Assumes the fixed 16-bit word and the three layouts described in the brief.
package iwd_pkg;
    localparam int WORD_W   = 16;
    localparam int OPC_W    = 8;
    localparam int REG_W    = 4;
    localparam int IMM_W    = 8;
    localparam int DFIELD_W = 10;
    localparam int BASE_LEN = 2;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_REG    = 2'd1,
        FORM_IMM    = 2'd2,
        FORM_BRANCH = 2'd3
    } form_e;

    // Legal opcode boundaries for the register layout and the branch layout
    localparam logic [OPC_W-1:0] REG_LOW_LAST   = 8'h0E;
    localparam logic [OPC_W-1:0] REG_HIGH_FIRST = 8'h19;
    localparam logic [OPC_W-1:0] REG_HIGH_LAST  = 8'h39;
    localparam logic [OPC_W-1:0] BR_LAST        = 8'h09;
endpackage

// File: rtl/iwd_field_split.sv
// Field extractor: picks the layout from the top bits of the word and
// routes opcode, register, immediate and displacement fields.
// Assumes DISP_W >= 11 so the doubled displacement fits with its sign.
module iwd_field_split
    import iwd_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output form_e             form,
    output logic [OPC_W-1:0]  opcode,
    output logic [REG_W-1:0]  reg_a,
    output logic [REG_W-1:0]  reg_b,
    output logic [IMM_W-1:0]  imm8,
    output logic [DISP_W-1:0] disp
);
    localparam int PAD_W = DISP_W - DFIELD_W - 1;

    logic [DISP_W-1:0] disp_ext;

    // Sign-extend the word displacement and turn it into a byte offset
    always_comb begin
        disp_ext = {{PAD_W{word[DFIELD_W-1]}}, word[DFIELD_W-1:0], 1'b0};
    end

    // Layout select and field routing; unused fields are forced to zero
    always_comb begin
        form   = FORM_NONE;
        opcode = '0;
        reg_a  = '0;
        reg_b  = '0;
        imm8   = '0;
        disp   = '0;
        if (!word[15]) begin
            form   = FORM_REG;
            opcode = word[15:8];
            reg_a  = word[7:4];
            reg_b  = word[3:0];
        end else if (!word[14]) begin
            form   = FORM_IMM;
            opcode = {6'b0, word[13:12]};
            reg_a  = word[11:8];
            imm8   = word[7:0];
        end else begin
            form   = FORM_BRANCH;
            opcode = {4'b0, word[13:10]};
            disp   = disp_ext;
        end
    end
endmodule

// File: rtl/iwd_opc_class.sv
// Opcode classifier: decides legality, whether a 32-bit literal follows,
// and the resulting instruction length in bytes.
// Assumes opcode is already zero-extended per layout by the field extractor.
module iwd_opc_class
    import iwd_pkg::*;
#(
    parameter int LIT_BYTES = 4,
    parameter int LEN_W     = 3
) (
    input  form_e            form,
    input  logic [OPC_W-1:0] opcode,
    output logic             illegal,
    output logic             needs_lit,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(BASE_LEN);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(BASE_LEN + LIT_BYTES);

    // Membership in the set of register-layout opcodes carrying a literal
    function automatic logic takes_literal(input logic [OPC_W-1:0] op);
        case (op)
            8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
            8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
            8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: takes_literal = 1'b1;
            default:                                 takes_literal = 1'b0;
        endcase
    endfunction

    logic reg_legal;
    logic br_legal;

    // Range checks for the two layouts that have holes in their code space
    always_comb begin
        reg_legal = (opcode <= REG_LOW_LAST) ||
                    ((opcode >= REG_HIGH_FIRST) && (opcode <= REG_HIGH_LAST));
        br_legal  = (opcode <= BR_LAST);
    end

    // Per-layout legality and literal flag
    always_comb begin
        illegal   = 1'b0;
        needs_lit = 1'b0;
        unique case (form)
            FORM_REG: begin
                illegal   = !reg_legal;
                needs_lit = reg_legal && takes_literal(opcode);
            end
            FORM_IMM:    illegal = 1'b0;
            FORM_BRANCH: illegal = !br_legal;
            default:     illegal = 1'b1;
        endcase
    end

    // Length follows the literal flag
    always_comb begin
        len = needs_lit ? LEN_LONG : LEN_SHORT;
    end
endmodule

// File: rtl/iword_decoder.sv
// Three-layout instruction decoder with one registered output stage.
// Fields load only on in_valid; out_valid tracks in_valid one clock later.
// Assumes synchronous active-low reset; no back-pressure on the output.
module iword_decoder
    import iwd_pkg::*;
#(
    parameter int DISP_W    = 16,
    parameter int LIT_BYTES = 4,
    parameter int LEN_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    output logic              out_valid,
    output logic [1:0]        out_form,
    output logic [7:0]        out_opcode,
    output logic [3:0]        out_reg_a,
    output logic [3:0]        out_reg_b,
    output logic [7:0]        out_imm8,
    output logic [DISP_W-1:0] out_disp,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_needs_lit,
    output logic              out_illegal
);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(BASE_LEN + LIT_BYTES);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(BASE_LEN);

    form_e             d_form;
    logic [OPC_W-1:0]  d_opcode;
    logic [REG_W-1:0]  d_reg_a;
    logic [REG_W-1:0]  d_reg_b;
    logic [IMM_W-1:0]  d_imm8;
    logic [DISP_W-1:0] d_disp;
    logic              d_illegal;
    logic              d_needs_lit;
    logic [LEN_W-1:0]  d_len;

    iwd_field_split #(.DISP_W(DISP_W)) u_split (
        .word   (in_word),
        .form   (d_form),
        .opcode (d_opcode),
        .reg_a  (d_reg_a),
        .reg_b  (d_reg_b),
        .imm8   (d_imm8),
        .disp   (d_disp)
    );

    iwd_opc_class #(.LIT_BYTES(LIT_BYTES), .LEN_W(LEN_W)) u_class (
        .form      (d_form),
        .opcode    (d_opcode),
        .illegal   (d_illegal),
        .needs_lit (d_needs_lit),
        .len       (d_len)
    );

    // Output valid follows the input strobe by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers load on a strobe and hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_form      <= '0;
            out_opcode    <= '0;
            out_reg_a     <= '0;
            out_reg_b     <= '0;
            out_imm8      <= '0;
            out_disp      <= '0;
            out_len       <= '0;
            out_needs_lit <= 1'b0;
            out_illegal   <= 1'b0;
        end else if (in_valid) begin
            out_form      <= d_form;
            out_opcode    <= d_opcode;
            out_reg_a     <= d_reg_a;
            out_reg_b     <= d_reg_b;
            out_imm8      <= d_imm8;
            out_disp      <= d_disp;
            out_len       <= d_len;
            out_needs_lit <= d_needs_lit;
            out_illegal   <= d_illegal;
        end
    end

    a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_opcode) && $stable(out_disp) && $stable(out_form)
                      && $stable(out_reg_a) && $stable(out_imm8));
    a_r1_form_known: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_form != 2'd0);
    a_r5_len_pair: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len == (out_needs_lit ? LEN_LONG : LEN_SHORT));
    a_r5_lit_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_needs_lit |-> !out_illegal && out_form == 2'd1);
    a_r7_imm_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 2'd2) |-> !out_illegal);
    a_r4_branch_no_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 2'd3) |-> out_reg_a == '0 && out_reg_b == '0 && out_imm8 == '0);
endmodule

// File: tb/iword_decoder_bench.sv
// Exhaustive sweep of all 16-bit words, plus hold and reset cases.
module iword_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DISP_W = 16;
    localparam int LEN_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_word = '0;
    logic              out_valid;
    logic [1:0]        out_form;
    logic [7:0]        out_opcode;
    logic [3:0]        out_reg_a;
    logic [3:0]        out_reg_b;
    logic [7:0]        out_imm8;
    logic [DISP_W-1:0] out_disp;
    logic [LEN_W-1:0]  out_len;
    logic              out_needs_lit;
    logic              out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iword_decoder u_iword_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_form(out_form), .out_opcode(out_opcode),
        .out_reg_a(out_reg_a), .out_reg_b(out_reg_b), .out_imm8(out_imm8),
        .out_disp(out_disp), .out_len(out_len), .out_needs_lit(out_needs_lit),
        .out_illegal(out_illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected outputs for one word, computed from the requirements
    task automatic check_word(input logic [15:0] w);
        int form, opc, ra, rb, imm, disp, len, lit, ill, f;
        ra = 0; rb = 0; imm = 0; disp = 0; lit = 0; ill = 0;
        if (w[15] == 1'b0) begin
            form = 1; opc = int'(w[15:8]); ra = int'(w[7:4]); rb = int'(w[3:0]);
            ill = ((opc <= 14) || (opc >= 25 && opc <= 57)) ? 0 : 1;
            if (ill == 0 && (opc inside {1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 34, 36, 48, 54, 55, 56, 57}))
                lit = 1;
        end else if (w[14] == 1'b0) begin
            form = 2; opc = int'(w[13:12]); ra = int'(w[11:8]); imm = int'(w[7:0]);
        end else begin
            form = 3; opc = int'(w[13:10]);
            f = int'(w[9:0]);
            if (f >= 512) f = f - 1024;
            disp = (f * 2) & 16'hFFFF;
            ill = (opc > 9) ? 1 : 0;
        end
        len = lit ? 6 : 2;
        chk("R8", "valid", int'(out_valid), 1);
        chk("R1", "form", int'(out_form), form);
        chk(form == 1 ? "R2" : form == 2 ? "R3" : "R4", "opcode", int'(out_opcode), opc);
        chk(form == 1 ? "R2" : "R3", "reg_a", int'(out_reg_a), ra);
        chk("R2", "reg_b", int'(out_reg_b), rb);
        chk("R3", "imm8", int'(out_imm8), imm);
        chk("R4", "disp", int'(out_disp), disp);
        chk("R5", "needs_lit", int'(out_needs_lit), lit);
        chk("R5", "len", int'(out_len), len);
        chk(form == 1 ? "R6" : "R7", "illegal", int'(out_illegal), ill);
    endtask

    initial begin
        // R10: reset with a strobe present keeps everything at zero
        in_valid = 1'b1;
        in_word  = 16'h0123;
        repeat (3) @(negedge clk);
        chk("R10", "valid", int'(out_valid), 0);
        chk("R10", "form", int'(out_form), 0);
        chk("R10", "opcode", int'(out_opcode), 0);
        chk("R10", "reg_a|reg_b", int'({out_reg_a, out_reg_b}), 0);
        chk("R10", "disp|imm8", int'(out_disp) | int'(out_imm8), 0);
        chk("R10", "len|lit|ill", int'({out_len, out_needs_lit, out_illegal}), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1..R7: every word, one per clock, checked one clock later
        for (int i = 0; i < 65536; i++) begin
            in_valid = 1'b1;
            in_word  = 16'(i);
            @(negedge clk);
            check_word(16'(i));
        end
        // R9: strobe drops with a different word on the input; fields hold
        in_valid = 1'b0;
        in_word  = 16'h0000;
        @(negedge clk);
        chk("R8", "valid after drop", int'(out_valid), 0);
        chk("R9", "form held", int'(out_form), 3);
        chk("R9", "opcode held", int'(out_opcode), 15);
        chk("R9", "disp held", int'(out_disp), 16'hFFFE);
        chk("R9", "illegal held", int'(out_illegal), 1);
        @(negedge clk);
        chk("R9", "opcode still held", int'(out_opcode), 15);
        // R8: a single strobe after a gap
        in_valid = 1'b1;
        in_word  = 16'h0301;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "valid after gap", int'(out_valid), 1);
        chk("R5", "len of 0x03", int'(out_len), 6);
        @(negedge clk);
        chk("R8", "valid one cycle only", int'(out_valid), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule